// File: doc/BRIEF.md
# SDRAM command-spacing enforcer

This block stands between an SDRAM command scheduler and the memory pins and holds each requested command back until the programmable cycle-count limits that apply to it have run out. The scheduler presents one command code with a valid flag. In the same cycle the block answers with a combinational grant if every timer that guards that command is at zero. A grant also starts the timer that the command itself triggers. The scheduler keeps a blocked request asserted and drops it after the grant.

Four limits are enforced, each by its own down-counter:
- spacing between REFRESH commands during the initialization sequence, taken from the refresh-cycle setting, or from precharge time plus minimum active time when that setting is zero;
- the delay from the final write data beat to a PRECHARGE;
- the latency from DQM being sampled until the memory releases the data bus;
- the dead cycles placed between the end of a read and the start of a write.

A data-bus drive enable covers the write data phase. Timing settings are copied into shadow registers only while the block is idle, so a counter that is already running never sees a changed value.

Control is a four-state machine:
- IDLE: all counters are zero and no data phase is open. The shadow registers follow the inputs here.
- WAIT: at least one counter is still running.
- READ: a read data phase is open.
- WRITE: a write data phase is open.

The transitions are:
- IDLE or WAIT go to READ on a READ grant and to WRITE on a WRITE grant. Otherwise they go to WAIT while any counter will be non-zero in the next cycle, and to IDLE when none will be.
- READ and WRITE stay put until `last_beat` is seen. They then leave for WAIT or IDLE by the same counter test.

Top module: `sdram_cmd_spacer`

## Requirements
- R1: While `init_mode` is 1, a REFRESH granted in cycle t blocks the next REFRESH until cycle t+N, where N is the shadowed refresh-cycle setting. A value that works out to 0 is treated as 1.
- R2: If the shadowed refresh-cycle setting is 0, N for R1 is the sum of the shadowed precharge time and minimum active time.
- R3: While `init_mode` is 0, REFRESH is granted whenever it is requested, with no spacing.
- R4: A PRECHARGE is not granted before cycle t+max(tDPL,1), where t is the cycle in which `last_beat` closes a write data phase.
- R5: If `last_beat` closes a read data phase in cycle t, a WRITE is not granted before cycle t+1+tRWT. A setting of 0 adds no dead cycle and 1 adds exactly one.
- R6: If `dqm_hiz` is sampled high in cycle t, a WRITE is not granted before cycle t+max(tDQZ,1).
- R7: The R5 dead cycles apply only when a write follows a read. A write after a write, or a read after a read, is granted in the cycle after `last_beat`.
- R8: Command codes are 0 none, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE and 5 REFRESH. `grant` is high only in a cycle where `req_valid` is high and the command is allowed. It never rises for code 0. READ and WRITE are refused while a data phase is open; ACTIVE is always allowed.
- R9: `drive_en` is high from the WRITE grant cycle up to and including the cycle with the final write beat, and low at all other times.
- R10: Timing settings are captured only in IDLE cycles. A change made while a counter runs does not alter that counter, and it takes effect after the block has been idle.
- R11: Synchronous active-high `rst` clears all counters and the state. Every command is grantable in the first cycle after reset, and `grant` and `drive_en` are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A command is being requested |
| req_cmd | input | 3 | Requested command code (see R8) |
| init_mode | input | 1 | Initialization sequence in progress (enables refresh spacing) |
| last_beat | input | 1 | Final data beat of the open read or write phase |
| dqm_hiz | input | 1 | DQM asserted to the memory this cycle |
| cfg_trc | input | CW | Refresh-to-refresh spacing during initialization |
| cfg_trp | input | CW | Precharge time, used in the fallback sum |
| cfg_tras | input | CW | Minimum active time, used in the fallback sum |
| cfg_tdpl | input | CW | Final write beat to PRECHARGE cycles |
| cfg_tdqz | input | CW | DQM to bus-release cycles |
| cfg_trwt | input | CW | Read-to-write dead cycles |
| grant | output | 1 | Requested command is issued this cycle |
| drive_en | output | 1 | Controller may drive the data bus |

## Verification
The hardest situation to reach from the ports is a write that waits on two limits at once: the read turnaround counter and the DQM release counter are both running, and which one expires last decides the grant cycle. The bench sweeps the dead-cycle and release settings together. It asserts DQM in three positions relative to the final read beat: not at all, one cycle before it, and on the same cycle. It then holds a write request and compares the first grant against the larger of the two computed limits. A second situation that needs care is the shadow capture. The bench changes the refresh setting while a spacing window is running and checks that the old spacing still holds, and that the new one applies only after the block has been idle.

// File: rtl/sdram_spacer_pkg.sv
package sdram_spacer_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } st_e;

endpackage

// File: rtl/spacer_downcnt.sv
module spacer_downcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero,
    output logic         zero_nx
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero    = (cnt_q == '0);
    assign zero_nx = load ? (load_val == '0) : (cnt_q <= W'(1));

    // R11: an expired counter stays expired until a new event reloads it
    assert_cnt_holds_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);

endmodule

// File: rtl/spacer_cfg_shadow.sv
module spacer_cfg_shadow #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample,
    input  logic [W-1:0] cfg_in,
    output logic [W-1:0] cfg_out
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_out <= '0;
        else if (sample)
            cfg_out <= cfg_in;
    end

    // R10: settings in force do not move outside idle cycles
    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(cfg_out));

endmodule

// File: rtl/sdram_cmd_spacer.sv
module sdram_cmd_spacer
    import sdram_spacer_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_cmd,
    input  logic          init_mode,
    input  logic          last_beat,
    input  logic          dqm_hiz,
    input  logic [CW-1:0] cfg_trc,
    input  logic [CW-1:0] cfg_trp,
    input  logic [CW-1:0] cfg_tras,
    input  logic [CW-1:0] cfg_tdpl,
    input  logic [CW-1:0] cfg_tdqz,
    input  logic [CW-1:0] cfg_trwt,
    output logic          grant,
    output logic          drive_en
);

    localparam int CW1   = CW + 1;
    localparam int NCFG  = 6;
    localparam int NT    = 3;
    localparam int T_DPL = 0;
    localparam int T_DQZ = 1;
    localparam int T_RWT = 2;

    st_e  st_q, st_d;
    cmd_e cmd;
    assign cmd = cmd_e'(req_cmd);

    // ---------------- configuration shadow ----------------
    logic [NCFG*CW-1:0] cfg_live, cfg_shd;
    logic               cfg_sample;
    logic [CW-1:0]      s_trc, s_trp, s_tras, s_tdpl, s_tdqz, s_trwt;

    assign cfg_live   = {cfg_trwt, cfg_tdqz, cfg_tdpl, cfg_tras, cfg_trp, cfg_trc};
    assign cfg_sample = (st_q == ST_IDLE);

    spacer_cfg_shadow #(.W(NCFG*CW)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .sample  (cfg_sample),
        .cfg_in  (cfg_live),
        .cfg_out (cfg_shd)
    );

    assign s_trc  = cfg_shd[0*CW +: CW];
    assign s_trp  = cfg_shd[1*CW +: CW];
    assign s_tras = cfg_shd[2*CW +: CW];
    assign s_tdpl = cfg_shd[3*CW +: CW];
    assign s_tdqz = cfg_shd[4*CW +: CW];
    assign s_trwt = cfg_shd[5*CW +: CW];

    // ---------------- events ----------------
    logic in_data, rd_end, wr_end, cmd_ok;
    assign in_data = (st_q == ST_READ) || (st_q == ST_WRITE);
    assign rd_end  = (st_q == ST_READ)  && last_beat;
    assign wr_end  = (st_q == ST_WRITE) && last_beat;

    // ---------------- refresh spacing counter ----------------
    logic [CW1-1:0] ref_base, ref_val;
    logic           ref_load, ref_zero, ref_znx;

    assign ref_base = (s_trc != '0) ? {1'b0, s_trc}
                                    : ({1'b0, s_trp} + {1'b0, s_tras});
    assign ref_val  = (ref_base == '0) ? '0 : ref_base - 1'b1;
    assign ref_load = grant && (cmd == CMD_REF) && init_mode;

    spacer_downcnt #(.W(CW1)) u_ref_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ref_load),
        .load_val (ref_val),
        .zero     (ref_zero),
        .zero_nx  (ref_znx)
    );

    // ---------------- data-bus timers ----------------
    logic [NT-1:0]         t_load, t_zero, t_znx;
    logic [NT-1:0][CW-1:0] t_val;

    assign t_load[T_DPL] = wr_end;
    assign t_val[T_DPL]  = (s_tdpl == '0) ? '0 : s_tdpl - 1'b1;
    assign t_load[T_DQZ] = dqm_hiz;
    assign t_val[T_DQZ]  = (s_tdqz == '0) ? '0 : s_tdqz - 1'b1;
    assign t_load[T_RWT] = rd_end;
    assign t_val[T_RWT]  = s_trwt;

    for (genvar gi = 0; gi < NT; gi++) begin : g_timer
        spacer_downcnt #(.W(CW)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (t_load[gi]),
            .load_val (t_val[gi]),
            .zero     (t_zero[gi]),
            .zero_nx  (t_znx[gi])
        );
    end

    logic bus_free, busy_nx;
    assign bus_free = t_zero[T_RWT] && t_zero[T_DQZ] && !dqm_hiz;
    assign busy_nx  = !(ref_znx && (&t_znx));

    // ---------------- admission ----------------
    always_comb begin
        unique case (cmd)
            CMD_ACT: cmd_ok = 1'b1;
            CMD_RD:  cmd_ok = !in_data;
            CMD_WR:  cmd_ok = !in_data && bus_free;
            CMD_PRE: cmd_ok = t_zero[T_DPL] && !wr_end;
            CMD_REF: cmd_ok = !init_mode || ref_zero;
            default: cmd_ok = 1'b0;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        unique case (st_q)
            ST_IDLE, ST_WAIT: begin
                if (grant && cmd == CMD_RD)
                    st_d = ST_READ;
                else if (grant && cmd == CMD_WR)
                    st_d = ST_WRITE;
                else
                    st_d = busy_nx ? ST_WAIT : ST_IDLE;
            end
            ST_READ, ST_WRITE: begin
                if (last_beat)
                    st_d = busy_nx ? ST_WAIT : ST_IDLE;
                else
                    st_d = st_q;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        grant    = !rst && req_valid && cmd_ok;
        drive_en = !rst && ((st_q == ST_WRITE) || (grant && cmd == CMD_WR));
    end

    // ---------------- assertions ----------------
    assert_grant_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
        grant |-> req_valid);

    assert_ref_spaced_R1: assert property (@(posedge clk) disable iff (rst)
        (grant && cmd == CMD_REF && init_mode) |-> ref_zero);

    assert_pre_after_dpl_R4: assert property (@(posedge clk) disable iff (rst)
        (grant && cmd == CMD_PRE) |-> t_zero[T_DPL]);

    assert_wr_after_turn_R5: assert property (@(posedge clk) disable iff (rst)
        (grant && cmd == CMD_WR) |-> (t_zero[T_RWT] && t_zero[T_DQZ]));

    assert_drive_ends_on_beat_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(drive_en) |-> $past(last_beat));

endmodule

// File: tb/sdram_cmd_spacer_tb.sv
module sdram_cmd_spacer_tb;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_cmd = 3'd0;
    logic          init_mode = 1'b0;
    logic          last_beat = 1'b0;
    logic          dqm_hiz = 1'b0;
    logic [CW-1:0] cfg_trc = '0, cfg_trp = '0, cfg_tras = '0;
    logic [CW-1:0] cfg_tdpl = '0, cfg_tdqz = '0, cfg_trwt = '0;
    logic          grant, drive_en;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [2:0] C_NONE = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                           C_WR = 3'd3, C_PRE = 3'd4, C_REF = 3'd5;

    always #2.5 clk = ~clk;

    sdram_cmd_spacer #(.CW(CW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .init_mode(init_mode), .last_beat(last_beat), .dqm_hiz(dqm_hiz),
        .cfg_trc(cfg_trc), .cfg_trp(cfg_trp), .cfg_tras(cfg_tras),
        .cfg_tdpl(cfg_tdpl), .cfg_tdqz(cfg_tdqz), .cfg_trwt(cfg_trwt),
        .grant(grant), .drive_en(drive_en)
    );

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(output logic g, output logic d);
        #1;
        g = grant;
        d = drive_en;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        logic g, d;
        req_valid = 1'b0; last_beat = 1'b0; dqm_hiz = 1'b0;
        for (int i = 0; i < n; i++) cyc(g, d);
    endtask

    task automatic wait_grant(input logic [2:0] c, output int n,
                              output logic drv_early, output logic d_at);
        logic g, d;
        n = 99; drv_early = 1'b0; d_at = 1'b0;
        req_valid = 1'b1; req_cmd = c;
        for (int i = 0; i < 40; i++) begin
            cyc(g, d);
            if (g) begin
                n = i; d_at = d;
                break;
            end
            if (d) drv_early = 1'b1;
        end
        req_valid = 1'b0;
    endtask

    task automatic set_cfg(int trc, int trp, int tras, int tdpl, int tdqz, int trwt);
        cfg_trc = CW'(trc); cfg_trp = CW'(trp); cfg_tras = CW'(tras);
        cfg_tdpl = CW'(tdpl); cfg_tdqz = CW'(tdqz); cfg_trwt = CW'(trwt);
    endtask

    // refresh pair: returns cycles from first grant to second grant
    task automatic ref_gap(output int gap);
        int n0, n1;
        logic de, da;
        init_mode = 1'b1;
        wait_grant(C_REF, n0, de, da);
        wait_grant(C_REF, n1, de, da);
        gap = n1 + 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n, gap;
        logic g, d, de, da;

        @(negedge clk);
        cyc(g, d);
        check("R11 grant in reset", int'(g), 0);
        check("R11 drive_en in reset", int'(d), 0);
        req_valid = 1'b1; req_cmd = C_WR;
        cyc(g, d);
        check("R11 grant held in reset", int'(g), 0);
        rst = 1'b0; req_valid = 1'b0;
        cyc(g, d);
        check("R11 idle grant after reset", int'(g), 0);
        check("R11 idle drive after reset", int'(d), 0);
        wait_grant(C_ACT, n, de, da);
        check("R11 ACT immediate", n, 0);

        // R1: explicit refresh spacing
        for (int t = 1; t <= 8; t++) begin
            set_cfg(t, 3, 2, 1, 1, 0); idle(3);
            ref_gap(gap);
            check($sformatf("R1 ref gap trc=%0d", t), gap, t);
            idle(t + 2);
        end
        // R2: fallback to precharge + active time
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 4; a++) begin
                set_cfg(0, p, a, 1, 1, 0); idle(3);
                ref_gap(gap);
                check($sformatf("R2 ref gap trp=%0d tras=%0d", p, a), gap, imax(p + a, 1));
                idle(p + a + 2);
            end
        end
        // R3: no spacing outside initialization
        set_cfg(7, 0, 0, 1, 1, 0); idle(3);
        init_mode = 1'b0;
        wait_grant(C_REF, n, de, da);
        wait_grant(C_REF, n, de, da);
        check("R3 ref back to back", n + 1, 1);
        idle(3);

        // R10: change during a running window
        set_cfg(6, 0, 0, 1, 1, 0); idle(3);
        init_mode = 1'b1;
        wait_grant(C_REF, n, de, da);
        cfg_trc = CW'(2);
        wait_grant(C_REF, n, de, da);
        check("R10 old spacing kept", n + 1, 6);
        idle(12);
        ref_gap(gap);
        check("R10 new spacing after idle", gap, 2);
        idle(4);
        init_mode = 1'b0;

        // R4 / R9: write to precharge
        for (int t = 0; t <= 5; t++) begin
            set_cfg(0, 0, 0, t, 1, 0); idle(3);
            wait_grant(C_WR, n, de, da);
            check("R9 write granted", n, 0);
            check("R9 drive at write grant", int'(da), 1);
            cyc(g, d);
            check("R9 drive mid burst", int'(d), 1);
            last_beat = 1'b1; req_valid = 1'b1; req_cmd = C_PRE;
            cyc(g, d);
            check("R4 pre blocked on last beat", int'(g), 0);
            check("R9 drive on last beat", int'(d), 1);
            last_beat = 1'b0;
            wait_grant(C_PRE, n, de, da);
            check($sformatf("R4 pre delay tdpl=%0d", t), n + 1, imax(t, 1));
            check("R9 drive low after burst", int'(de | da), 0);
            idle(8);
        end

        // R5 / R6: read to write with turnaround and DQM release
        for (int w = 0; w < 4; w++) begin
            for (int q = 0; q < 4; q++) begin
                for (int m = 0; m < 3; m++) begin
                    int exp;
                    set_cfg(0, 0, 0, 1, q, w); idle(3);
                    wait_grant(C_RD, n, de, da);
                    dqm_hiz = (m == 1);
                    cyc(g, d);
                    dqm_hiz = (m == 2); last_beat = 1'b1;
                    req_valid = 1'b1; req_cmd = C_WR;
                    cyc(g, d);
                    check("R8 write blocked in read", int'(g), 0);
                    check("R9 no drive in read", int'(d), 0);
                    dqm_hiz = 1'b0; last_beat = 1'b0;
                    wait_grant(C_WR, n, de, da);
                    exp = (m == 0) ? w
                        : (m == 1) ? imax(w, imax(q, 1) - 2)
                        :            imax(w, imax(q, 1) - 1);
                    check($sformatf("%s turn trwt=%0d tdqz=%0d mode=%0d",
                                    (m == 0) ? "R5" : "R6", w, q, m), n, exp);
                    check("R9 drive held until free", int'(de), 0);
                    check("R9 drive at grant", int'(da), 1);
                    last_beat = 1'b1;
                    cyc(g, d);
                    idle(6);
                end
            end
        end

        // R7: same-direction transfers get no dead cycles
        set_cfg(0, 0, 0, 1, 3, 3); idle(3);
        wait_grant(C_WR, n, de, da);
        last_beat = 1'b1; cyc(g, d); last_beat = 1'b0;
        wait_grant(C_WR, n, de, da);
        check("R7 write after write", n, 0);
        last_beat = 1'b1; cyc(g, d);
        idle(4);
        wait_grant(C_RD, n, de, da);
        last_beat = 1'b1; cyc(g, d); last_beat = 1'b0;
        wait_grant(C_RD, n, de, da);
        check("R7 read after read", n, 0);
        last_beat = 1'b1; cyc(g, d);
        idle(8);

        // R8: admission during an open read
        wait_grant(C_RD, n, de, da);
        req_valid = 1'b1; req_cmd = C_RD; cyc(g, d);
        check("R8 read refused in read", int'(g), 0);
        req_cmd = C_ACT; cyc(g, d);
        check("R8 ACT allowed in read", int'(g), 1);
        req_valid = 1'b0; cyc(g, d);
        check("R8 no grant without valid", int'(g), 0);
        req_valid = 1'b1; req_cmd = C_NONE; cyc(g, d);
        check("R8 no grant for none", int'(g), 0);
        req_cmd = C_PRE; cyc(g, d);
        check("R8 PRE allowed in read", int'(g), 1);
        req_valid = 1'b0; last_beat = 1'b1; cyc(g, d);
        idle(6);

        // R11: reset in the middle of a spacing window
        set_cfg(9, 0, 0, 1, 1, 0); idle(3);
        init_mode = 1'b1;
        wait_grant(C_REF, n, de, da);
        rst = 1'b1; idle(2); rst = 1'b0;
        wait_grant(C_REF, n, de, da);
        check("R11 ref free after reset", n, 0);
        idle(3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule